// File: doc/BRIEF.md
# Commit-Stage Interrupt Acceptance Controller

This block sits beside the commit stage of an out-of-order core. It decides, cycle by cycle, whether an external interrupt is accepted. The interrupt arrives on a level-sensitive request line together with a cause code.

When a request can be accepted, the controller captures it and the cause, and sends fetch a one-cycle hold pulse so that fetch stops issuing new work. It then waits in an armed state until the reorder buffer is empty and no stores are waiting for writeback. At that point it starts the handler with the captured cause, asks for a trap squash, and raises a trap-pending flag. The flag stays up until the trap logic reports completion.

The source may withdraw its request while the controller is armed. In that case the controller sends fetch a release pulse and returns to idle. Fetch then resumes on the original path instead of waiting forever for an interrupt that will never be taken.

The state machine has two states:
- `ST_IDLE` moves to `ST_ARMED` on the transition "capture". A capture happens when the request is high, trap-pending is clear, no trap squash is active and no external squash is active.
- `ST_ARMED` returns to `ST_IDLE` on one of two transitions:
  - "withdraw": the request is low.
  - "take": the request is high and the pipeline has drained.
- In every other case `ST_ARMED` holds, on the transition "wait".

Top module: `irq_accept_ctrl`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `trap_pending_o` is 0, the controller is idle, and no pulse output is high while all inputs are low.
- R2: In idle with `irq_req_i` high and no inhibit active, `fetch_hold_o` is 1 in that same cycle, and the controller is armed from the next edge.
- R3: No capture occurs, and `fetch_hold_o` stays 0, while any of the following is true: `trap_pending_o` is 1, an interrupt is already captured, `trap_squash_i` is 1, or `ext_squash_i` is 1.
- R4: The cause is registered at capture. `handler_cause_o` presents that registered value, even if `irq_cause_i` changes later.
- R5: While armed with the request high, `handler_start_o` stays 0 whenever `rob_empty_i` is 0 or `stores_pend_i` is 1.
- R6: While armed, a low `irq_req_i` gives a `fetch_release_o` pulse with no handler start, and the controller returns to idle, where a new request can be captured again.
- R7: While armed with the request high, `rob_empty_i`=1 and `stores_pend_i`=0, the controller drives `fetch_release_o`, `handler_start_o` and `trap_squash_req_o` all to 1 in the same cycle. `trap_pending_o` is 1 from the next cycle.
- R8: The armed-state decision is evaluated before capture. An interrupt captured in one cycle is never started in that same cycle, even if the pipeline is already drained.
- R9: `trap_pending_o` stays 1 until a cycle with `trap_done_i` high, and reads 0 from the following cycle.
- R10: `fetch_hold_o`, `fetch_release_o`, `handler_start_o` and `trap_squash_req_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req_i | input | 1 | Level-sensitive interrupt request |
| irq_cause_i | input | CAUSE_W | Cause code accompanying the request |
| rob_empty_i | input | 1 | Reorder buffer is empty |
| stores_pend_i | input | 1 | Stores still waiting for writeback |
| trap_squash_i | input | 1 | Trap squash in progress |
| ext_squash_i | input | 1 | External squash in progress |
| trap_done_i | input | 1 | Trap handling finished; clears trap-pending |
| fetch_hold_o | output | 1 | Pulse: interrupt captured, fetch must stop |
| fetch_release_o | output | 1 | Pulse: captured interrupt resolved, fetch may resume |
| handler_start_o | output | 1 | Pulse: start the interrupt handler |
| handler_cause_o | output | CAUSE_W | Registered cause for the handler |
| trap_squash_req_o | output | 1 | Pulse: request a trap squash |
| trap_pending_o | output | 1 | Trap accepted and not yet finished |

## Verification
The take path is driven with a request whose cause input changes after capture. The drain inputs are released one at a time, so that the reorder-buffer condition and the store condition are shown to block the start separately. A start taken with the original cause shows the cause is registered.

A second pattern drops the request while armed and the pipeline is not drained. This separates the withdraw transition from the take transition: a release pulse with no start is expected.

A third pattern raises the request under each of the four inhibits. After each, the request and the inhibit are dropped together. A release pulse on the next cycle would then expose a capture that should have been blocked.

A capture with the pipeline already drained shows that a capture and a start never share a cycle.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } acc_state_e;

endpackage

// File: rtl/irq_latch_gate.sv
module irq_latch_gate (
    input  logic irq_req,
    input  logic trap_pending,
    input  logic armed,
    input  logic trap_squash,
    input  logic ext_squash,
    output logic may_capture
);

    logic inhibit;

    always_comb begin
        inhibit     = trap_pending | armed | trap_squash | ext_squash;
        may_capture = irq_req & ~inhibit;
    end

endmodule

// File: rtl/irq_trap_flag.sv
module irq_trap_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pending_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_o <= 1'b0;
        end else if (set_i) begin
            pending_o <= 1'b1;
        end else if (clr_i) begin
            pending_o <= 1'b0;
        end
    end

    AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pending_o && !clr_i) |=> pending_o); // R9

    AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (pending_o && clr_i && !set_i) |=> !pending_o); // R9

endmodule

// File: rtl/irq_accept_fsm.sv
module irq_accept_fsm
    import irq_accept_pkg::*;
#(
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_req,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic               drained,
    input  logic               may_capture,
    output logic               armed,
    output logic               hold_pulse,
    output logic               release_pulse,
    output logic               start_pulse,
    output logic [CAUSE_W-1:0] cause_q
);

    acc_state_e state_q;
    acc_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            if (hold_pulse) begin
                cause_q <= cause_in;
            end
        end
    end

    always_comb begin
        state_d       = state_q;
        hold_pulse    = 1'b0;
        release_pulse = 1'b0;
        start_pulse   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (may_capture) begin
                    hold_pulse = 1'b1;
                    state_d    = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!irq_req) begin
                    release_pulse = 1'b1;
                    state_d       = ST_IDLE;
                end else if (drained) begin
                    release_pulse = 1'b1;
                    start_pulse   = 1'b1;
                    state_d       = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign armed = (state_q == ST_ARMED);

    AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (armed && !hold_pulse) |=> $stable(cause_q)); // R4

    AST_HOLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        hold_pulse |=> !hold_pulse); // R10

    AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (rst)
        release_pulse |=> !release_pulse); // R10

    AST_NO_SAME_CYCLE_TAKE: assert property (@(posedge clk) disable iff (rst)
        hold_pulse |-> !start_pulse); // R8

    AST_START_ONLY_ARMED: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(hold_pulse) || armed); // R8

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl #(
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_req_i,
    input  logic [CAUSE_W-1:0] irq_cause_i,
    input  logic               rob_empty_i,
    input  logic               stores_pend_i,
    input  logic               trap_squash_i,
    input  logic               ext_squash_i,
    input  logic               trap_done_i,
    output logic               fetch_hold_o,
    output logic               fetch_release_o,
    output logic               handler_start_o,
    output logic [CAUSE_W-1:0] handler_cause_o,
    output logic               trap_squash_req_o,
    output logic               trap_pending_o
);

    logic drained;
    logic armed;
    logic may_capture;

    assign drained = rob_empty_i & ~stores_pend_i;

    irq_latch_gate u_gate (
        .irq_req      (irq_req_i),
        .trap_pending (trap_pending_o),
        .armed        (armed),
        .trap_squash  (trap_squash_i),
        .ext_squash   (ext_squash_i),
        .may_capture  (may_capture)
    );

    irq_accept_fsm #(
        .CAUSE_W (CAUSE_W)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .irq_req       (irq_req_i),
        .cause_in      (irq_cause_i),
        .drained       (drained),
        .may_capture   (may_capture),
        .armed         (armed),
        .hold_pulse    (fetch_hold_o),
        .release_pulse (fetch_release_o),
        .start_pulse   (handler_start_o),
        .cause_q       (handler_cause_o)
    );

    irq_trap_flag u_trap (
        .clk       (clk),
        .rst       (rst),
        .set_i     (handler_start_o),
        .clr_i     (trap_done_i),
        .pending_o (trap_pending_o)
    );

    assign trap_squash_req_o = handler_start_o;

    AST_START_SETS_TRAP: assert property (@(posedge clk) disable iff (rst)
        handler_start_o |=> trap_pending_o); // R7

    AST_NO_CAPTURE_IN_TRAP: assert property (@(posedge clk) disable iff (rst)
        trap_pending_o |-> !fetch_hold_o); // R3

    AST_NO_CAPTURE_SQUASH: assert property (@(posedge clk) disable iff (rst)
        (trap_squash_i || ext_squash_i) |-> !fetch_hold_o); // R3

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        handler_start_o |=> !handler_start_o); // R10

    AST_START_DRAINED: assert property (@(posedge clk) disable iff (rst)
        handler_start_o |-> (rob_empty_i && !stores_pend_i && irq_req_i)); // R5

endmodule

// File: tb/irq_accept_ctrl_bench.sv
module irq_accept_ctrl_bench;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          irq, rob, stp, tsq, esq, tdn;
    logic [CW-1:0] cause;
    logic          hold, rel, start, sqr, tpend;
    logic [CW-1:0] hcause;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    irq_accept_ctrl #(.CAUSE_W(CW)) u_irq_accept_ctrl (
        .clk               (clk),
        .rst               (rst),
        .irq_req_i         (irq),
        .irq_cause_i       (cause),
        .rob_empty_i       (rob),
        .stores_pend_i     (stp),
        .trap_squash_i     (tsq),
        .ext_squash_i      (esq),
        .trap_done_i       (tdn),
        .fetch_hold_o      (hold),
        .fetch_release_o   (rel),
        .handler_start_o   (start),
        .handler_cause_o   (hcause),
        .trap_squash_req_o (sqr),
        .trap_pending_o    (tpend)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // Next cycle: wait for negedge, apply inputs, settle 1 ns before checking.
    task automatic cyc(input logic i, input logic [CW-1:0] c, input logic r,
                       input logic s, input logic t, input logic e, input logic d);
        @(negedge clk);
        irq = i; cause = c; rob = r; stp = s; tsq = t; esq = e; tdn = d;
        #1;
    endtask

    task automatic t_reset;
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R1", "trap_pending", tpend, 0);
        chk("R1", "hold", hold, 0);
        chk("R1", "release", rel, 0);
        chk("R1", "start", start, 0);
        chk("R1", "squash_req", sqr, 0);
    endtask

    task automatic t_take;
        cyc(1, 4'hA, 1, 0, 0, 0, 0);               // capture, already drained
        chk("R2", "hold on capture", hold, 1);
        chk("R8", "no start on capture cycle", start, 0);
        cyc(1, 4'h3, 0, 0, 0, 0, 0);               // ROB not empty
        chk("R10", "hold one cycle", hold, 0);
        chk("R5", "wait on rob", start, 0);
        cyc(1, 4'h3, 1, 1, 0, 0, 0);               // stores pending
        chk("R5", "wait on stores", start, 0);
        chk("R5", "no release while waiting", rel, 0);
        cyc(1, 4'h3, 1, 0, 0, 0, 0);               // drained: take
        chk("R7", "start", start, 1);
        chk("R7", "release", rel, 1);
        chk("R7", "squash_req", sqr, 1);
        chk("R4", "registered cause", hcause, 4'hA);
        cyc(1, 4'h3, 1, 0, 0, 0, 0);
        chk("R7", "trap_pending set", tpend, 1);
        chk("R10", "start one cycle", start, 0);
        chk("R10", "squash one cycle", sqr, 0);
        chk("R3", "no capture in trap", hold, 0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R9", "trap_pending holds", tpend, 1);
        cyc(0, 0, 1, 0, 0, 0, 1);
        chk("R9", "still set on done cycle", tpend, 1);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R9", "cleared after done", tpend, 0);
    endtask

    task automatic t_cancel;
        cyc(1, 4'h5, 0, 1, 0, 0, 0);
        chk("R2", "hold", hold, 1);
        cyc(0, 4'h5, 0, 1, 0, 0, 0);               // withdraw
        chk("R6", "release", rel, 1);
        chk("R6", "no start", start, 0);
        chk("R6", "no trap", sqr, 0);
        cyc(0, 4'h5, 0, 1, 0, 0, 0);
        chk("R10", "release one cycle", rel, 0);
        chk("R6", "trap not pending", tpend, 0);
        cyc(1, 4'h6, 0, 1, 0, 0, 0);               // idle again: recapture
        chk("R6", "recapture", hold, 1);
        cyc(0, 4'h6, 0, 1, 0, 0, 0);
        chk("R6", "second release", rel, 1);
    endtask

    // Raise request under an inhibit, then drop both; a release would reveal a capture.
    task automatic t_inhibit;
        cyc(1, 4'h1, 0, 0, 1, 0, 0);
        chk("R3", "trap squash blocks", hold, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R3", "trap squash no capture", rel, 0);
        cyc(1, 4'h2, 0, 0, 0, 1, 0);
        chk("R3", "ext squash blocks", hold, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R3", "ext squash no capture", rel, 0);
        cyc(1, 4'h7, 0, 0, 0, 0, 0);               // capture
        chk("R2", "hold", hold, 1);
        cyc(1, 4'h8, 0, 0, 0, 0, 0);
        chk("R3", "already captured blocks", hold, 0);
        cyc(1, 4'h8, 1, 0, 0, 0, 0);               // take
        chk("R4", "first cause kept", hcause, 4'h7);
        cyc(1, 4'h9, 1, 0, 0, 0, 0);
        chk("R3", "trap pending blocks", hold, 0);
        cyc(0, 0, 1, 0, 0, 0, 1);
        chk("R3", "trap pending no capture", rel, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R9", "clear", tpend, 0);
    endtask

    initial begin
        rst = 1; irq = 0; cause = 0; rob = 0; stp = 0; tsq = 0; esq = 0; tdn = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_take();
        t_cancel();
        t_inhibit();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule